// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind the protocol engine of a serial memory slave. The engine first hands it a word address and then a series of received data bytes. The block holds those bytes in a small page latch, one slot per low-order address value. It keeps the word pointer that the engine reads. On each accepted byte, only the in-page bits of that pointer advance.

When the engine reports the stop condition that closes the transaction, the block starts a self-timed write interval. It raises `busy` and, during that interval, strobes every filled slot into an external synchronous byte array. A hardware write-inhibit input blocks the whole write path. The length of the interval is a cycle-count parameter sized for the worst-case programming time. While `busy` is high, the engine is expected to ignore the bus, and the block itself drops every request.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy`, `mem_we` and `data_ack` are low and `ptr` is 0.
- R2: A word-address load while idle sets `ptr` to `addr_val`. Each acknowledged data byte adds one to `ptr` modulo 2^PAGE_W (bits [1:0] by default) and leaves the upper bits unchanged.
- R3: When more than 2^PAGE_W bytes arrive in one transaction, the in-page pointer wraps. A later byte for a slot replaces the earlier one, and only the last value reaches the array.
- R4: No array write happens before the stop pulse. `busy` rises in the cycle after a stop that starts a commit and stays high for exactly WR_CYCLES clock cycles.
- R5: While `busy` is high, `data_ack` stays low. Data strobes, address loads and stop pulses have no effect on `ptr`, on the buffered slots or on the array.
- R6: If `wlock` is high when the stop pulse arrives, no busy interval starts and nothing is written. The buffered bytes are discarded.
- R7: A byte that arrives while `wlock` is high is not buffered. It is acknowledged, and advances `ptr`, only when ACK_WHEN_LOCKED is 1 (the default).
- R8: The commit writes only the slots that received a byte, at address {ptr[ADDR_W-1:PAGE_W], slot}. It does so within the first 2^PAGE_W cycles of `busy`, and all other array locations keep their contents.
- R9: A stop pulse with an empty buffer starts no busy interval and writes nothing.
- R10: In the cycle `busy` falls, `ptr` holds the last page address written and the buffer is empty, so a further stop starts nothing.
- R11: A word-address load while idle discards bytes buffered since the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Word-address load strobe from the engine |
| addr_val | input | ADDR_W | Word address to load |
| dat_vld | input | 1 | Received data byte strobe |
| dat_val | input | DATA_W | Received data byte |
| stop_pulse | input | 1 | One-cycle pulse on the closing stop condition |
| wlock | input | 1 | High inhibits all writes |
| data_ack | output | 1 | Byte acknowledged (combinational with `dat_vld`) |
| busy | output | 1 | Self-timed write interval in progress |
| ptr | output | ADDR_W | Word pointer seen by the engine |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The bench sweeps every page with 0 to 6 bytes from a rotating start offset and keeps its own shadow of the array.

- **Wrap-around.** A design that advanced the upper address bits would spill into the next page and corrupt memory there.
- **Overwrite.** A design that kept the first byte of an overwritten slot would leave stale data.
- **Full page.** A design that wrote the whole page would clobber slots that were never sent.
- **Interval length.** The bench counts the `busy` interval against WR_CYCLES, so an off-by-one timer shows up.
- **Busy and lock.** Bytes, loads and stops are injected during `busy`, and stops are issued with `wlock` high. A design that leaked those requests would move the pointer or write the array.
- **Stale buffer.** Follow-up stops after an aborted or completed commit catch a buffer that was not cleared.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   localparam int unsigned PGW_ADDR_W_DEF = 8;
   localparam int unsigned PGW_DATA_W_DEF = 8;
   localparam int unsigned PGW_PAGE_W_DEF = 2;

   // width of a counter able to hold the value n
   function automatic int unsigned pgw_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pgwr_slots.sv
module pgwr_slots #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cap,
   input  logic [PAGE_W-1:0]      cap_slot,
   input  logic [DATA_W-1:0]      cap_data,
   input  logic                   clr,
   input  logic [PAGE_W-1:0]      rd_slot,
   output logic [(1<<PAGE_W)-1:0] vld,
   output logic [DATA_W-1:0]      rd_data
);
   localparam int unsigned N = 1 << PAGE_W;

   logic [N-1:0][DATA_W-1:0] slot_data;

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (cap && (cap_slot == PAGE_W'(i))) begin
            v_q <= 1'b1;
            d_q <= cap_data;
         end
      end
      assign vld[i]       = v_q;
      assign slot_data[i] = d_q;
   end

   assign rd_data = slot_data[rd_slot];
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int unsigned WR_CYCLES = 16,
   parameter int unsigned CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [CNT_W-1:0] tick,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (cnt_q == LAST) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign tick = cnt_q;
   assign done = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
   import pgwr_pkg::*;
#(
   parameter int unsigned ADDR_W          = PGW_ADDR_W_DEF,
   parameter int unsigned DATA_W          = PGW_DATA_W_DEF,
   parameter int unsigned PAGE_W          = PGW_PAGE_W_DEF,
   parameter int unsigned WR_CYCLES       = 500000,
   parameter bit          ACK_WHEN_LOCKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] addr_val,
   input  logic              dat_vld,
   input  logic [DATA_W-1:0] dat_val,
   input  logic              stop_pulse,
   input  logic              wlock,
   output logic              data_ack,
   output logic              busy,
   output logic [ADDR_W-1:0] ptr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int unsigned PAGE_N = 1 << PAGE_W;
   localparam int unsigned CNT_W  = pgw_cnt_w(WR_CYCLES);

   initial begin
      assert (PAGE_W >= 1 && PAGE_W < ADDR_W)
         else $error("pgwr_commit: PAGE_W must lie in 1..ADDR_W-1");
      assert (WR_CYCLES > PAGE_N)
         else $error("pgwr_commit: WR_CYCLES must exceed the page size");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [PAGE_W-1:0] last_q;
   logic [PAGE_N-1:0] slot_vld;
   logic [CNT_W-1:0]  tick;
   logic              done;
   logic              ack_ok;
   logic              accept;
   logic              cap;
   logic              start;
   logic              clr;
   logic [PAGE_W-1:0] wr_slot;
   logic              walking;

   // acknowledge policy while writes are inhibited
   if (ACK_WHEN_LOCKED) begin : g_ack_keep
      assign ack_ok = 1'b1;
   end else begin : g_ack_drop
      assign ack_ok = ~wlock;
   end

   assign accept = dat_vld & ~busy & ack_ok;
   assign cap    = dat_vld & ~busy & ~wlock;
   assign start  = stop_pulse & ~busy & ~wlock & (|slot_vld);
   assign clr    = done | (stop_pulse & ~busy & ~start) | (addr_ld & ~busy);

   pgwr_slots #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .cap_slot (ptr_q[PAGE_W-1:0]),
      .cap_data (dat_val),
      .clr      (clr),
      .rd_slot  (wr_slot),
      .vld      (slot_vld),
      .rd_data  (mem_wdata)
   );

   pgwr_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .tick  (tick),
      .done  (done)
   );

   // word pointer: only the in-page bits move on data bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         last_q <= '0;
      end else if (done) begin
         ptr_q[PAGE_W-1:0] <= last_q;
      end else if (!busy) begin
         if (addr_ld) begin
            ptr_q <= addr_val;
         end else if (accept) begin
            ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
            if (cap) last_q <= ptr_q[PAGE_W-1:0];
         end
      end
   end

   // commit walk over the first PAGE_N cycles of the interval
   assign walking  = busy && (int'(tick) < int'(PAGE_N));
   assign wr_slot  = tick[PAGE_W-1:0];
   assign mem_we   = walking && slot_vld[wr_slot];
   assign mem_addr = {ptr_q[ADDR_W-1:PAGE_W], wr_slot};
   assign data_ack = accept;
   assign ptr      = ptr_q;
endmodule

module pgwr_commit_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PAGE_W    = 2,
   parameter int unsigned WR_CYCLES = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   stop_pulse,
   input logic                   wlock,
   input logic                   data_ack,
   input logic                   busy,
   input logic                   mem_we,
   input logic [ADDR_W-1:0]      ptr,
   input logic [(1<<PAGE_W)-1:0] slot_vld
);
   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else run_q <= 0;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == WR_CYCLES); // R4
   AST_BUSY_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_pulse && !wlock)); // R6
   AST_ACK_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      data_ack |-> !busy); // R5
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(ptr)); // R5
   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy); // R8
   AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse && !busy && slot_vld == '0 |=> !busy); // R9
endmodule

bind pgwr_commit pgwr_commit_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_pulse (stop_pulse),
   .wlock      (wlock),
   .data_ack   (data_ack),
   .busy       (busy),
   .mem_we     (mem_we),
   .ptr        (ptr),
   .slot_vld   (slot_vld)
);

// File: tb/sim_pgwr_commit.sv
module sim_pgwr_commit;
   localparam int WR = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_ld = 1'b0;
   logic [7:0] addr_val = '0;
   logic       dat_vld = 1'b0;
   logic [7:0] dat_val = '0;
   logic       stop_pulse = 1'b0;
   logic       wlock = 1'b0;
   logic       data_ack, busy, mem_we;
   logic [7:0] ptr, mem_addr, mem_wdata;

   always #5 clk = ~clk;

   pgwr_commit #(.WR_CYCLES(WR)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_val(addr_val),
      .dat_vld(dat_vld), .dat_val(dat_val), .stop_pulse(stop_pulse),
      .wlock(wlock), .data_ack(data_ack), .busy(busy), .ptr(ptr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   // array model driven by the block, plus a write counter
   logic [7:0] arr [256];
   int         wr_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) arr[i] <= 8'((i * 3) ^ 8'h5A);
         wr_cnt <= 0;
      end else if (mem_we) begin
         arr[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   logic [7:0] exp_mem [256];
   logic [7:0] m_ptr;
   bit         bv [4];
   logic [7:0] bd [4];
   logic [1:0] m_last;
   int         checks = 0;
   int         fails = 0;
   bit         ended = 0;

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   task automatic load_addr(input logic [7:0] a);
      @(negedge clk); addr_ld = 1'b1; addr_val = a;
      @(negedge clk); addr_ld = 1'b0;
      m_ptr = a;
      for (int s = 0; s < 4; s++) bv[s] = 0;
      chk("R2 ptr after load", int'(ptr), int'(m_ptr));
   endtask

   task automatic send(input logic [7:0] d, input bit exp_ack, input bit exp_buf);
      @(negedge clk); dat_vld = 1'b1; dat_val = d;
      #1 chk("R7/R5 data_ack", int'(data_ack), int'(exp_ack));
      @(negedge clk); dat_vld = 1'b0;
      if (exp_buf) begin
         bv[m_ptr[1:0]] = 1;
         bd[m_ptr[1:0]] = d;
         m_last = m_ptr[1:0];
      end
      if (exp_ack) m_ptr[1:0] = m_ptr[1:0] + 2'd1;
      chk("R2 ptr after byte", int'(ptr), int'(m_ptr));
   endtask

   task automatic do_stop();
      int  w0, n, nv;
      bit  any;
      w0 = wr_cnt;
      any = 0; nv = 0;
      for (int s = 0; s < 4; s++) if (bv[s]) begin any = 1; nv++; end
      chk("R4 no write before stop", wr_cnt, w0);
      @(negedge clk); stop_pulse = 1'b1;
      @(negedge clk); stop_pulse = 1'b0;
      if (any && !wlock) begin
         n = 0;
         while (busy && n < 100) begin n++; @(negedge clk); end
         chk("R4 busy length", n, WR);
         chk("R8 writes issued", wr_cnt - w0, nv);
         for (int s = 0; s < 4; s++) begin
            if (bv[s]) exp_mem[{m_ptr[7:2], 2'(s)}] = bd[s];
            chk("R3/R8 page cell", int'(arr[{m_ptr[7:2], 2'(s)}]),
                int'(exp_mem[{m_ptr[7:2], 2'(s)}]));
         end
         m_ptr[1:0] = m_last;
         chk("R10 ptr after commit", int'(ptr), int'(m_ptr));
      end else begin
         repeat (3) @(negedge clk);
         chk("R6/R9 no busy", int'(busy), 0);
         chk("R6/R9 no write", wr_cnt - w0, 0);
      end
      for (int s = 0; s < 4; s++) bv[s] = 0;
   endtask

   initial begin
      repeat (WR * 10000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int w0, n;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'((i * 3) ^ 8'h5A);
      for (int s = 0; s < 4; s++) begin bv[s] = 0; bd[s] = '0; end
      m_ptr = '0; m_last = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 mem_we in reset", int'(mem_we), 0);
      chk("R1 data_ack in reset", int'(data_ack), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ptr after reset", int'(ptr), 0);
      chk("R1 busy after reset", int'(busy), 0);

      // sweep every page, 0..6 bytes, rotating start offset (R2 R3 R8 R9 R10)
      for (int p = 0; p < 64; p++) begin
         for (int nb = 0; nb < 7; nb++) begin
            load_addr(8'(p * 4 + ((p + nb) & 3)));
            for (int k = 0; k < nb; k++) send(8'(p * 37 + nb * 11 + k * 5 + 3), 1, 1);
            do_stop();
         end
      end

      // R5: requests during busy are dropped
      load_addr(8'h40);
      send(8'h11, 1, 1);
      send(8'h22, 1, 1);
      w0 = wr_cnt;
      @(negedge clk); stop_pulse = 1'b1;
      @(negedge clk); stop_pulse = 1'b0;
      chk("R4 busy raised", int'(busy), 1);
      @(negedge clk); dat_vld = 1'b1; dat_val = 8'hEE;
      #1 chk("R5 no ack in busy", int'(data_ack), 0);
      @(negedge clk); dat_vld = 1'b0; addr_ld = 1'b1; addr_val = 8'h99;
      @(negedge clk); addr_ld = 1'b0; stop_pulse = 1'b1;
      @(negedge clk); stop_pulse = 1'b0;
      chk("R5 ptr held", int'(ptr), 8'h42);
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      exp_mem[8'h40] = 8'h11; exp_mem[8'h41] = 8'h22;
      chk("R5 writes in busy", wr_cnt - w0, 2);
      chk("R5 slot 2 untouched", int'(arr[8'h42]), int'(exp_mem[8'h42]));
      chk("R5 slot 0", int'(arr[8'h40]), 8'h11);
      chk("R10 ptr last written", int'(ptr), 8'h41);
      m_ptr = 8'h41;
      for (int s = 0; s < 4; s++) bv[s] = 0;
      do_stop();   // R10 buffer empty: no second commit

      // R6: lock at stop discards the page
      load_addr(8'h80);
      send(8'hA1, 1, 1);
      send(8'hA2, 1, 1);
      wlock = 1'b1;
      do_stop();
      wlock = 1'b0;
      do_stop();   // R6 bytes were discarded
      chk("R6 cell kept", int'(arr[8'h80]), int'(exp_mem[8'h80]));

      // R7: bytes under lock are acknowledged but not buffered
      wlock = 1'b1;
      load_addr(8'h93);
      send(8'h5C, 1, 0);
      chk("R7 ptr wrapped in page", int'(ptr), 8'h90);
      wlock = 1'b0;
      do_stop();
      chk("R7 cell kept", int'(arr[8'h93]), int'(exp_mem[8'h93]));

      // R11: new address load discards buffered bytes
      load_addr(8'hA0);
      send(8'h77, 1, 1);
      load_addr(8'hB0);
      do_stop();
      chk("R11 cell kept", int'(arr[8'hA0]), int'(exp_mem[8'hA0]));

      // R8: whole array matches the shadow
      n = 0;
      for (int i = 0; i < 256; i++) if (arr[i] != exp_mem[i]) n++;
      chk("R8 full array mismatches", n, 0);
      summary();
   end
endmodule